// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block sits between a host port and a word-addressed memory array and drives the array address during synchronous burst reads. The host pulls an active-low address strobe for one clock and presents a start address, a wrap mode and a count of initial wait states. The block then waits that many cycles and steps the array address through the aligned group that holds the start address. The group is 8, 16 or 32 words. At the top of the group the address returns to the group's lowest word. One word is delivered in every cycle in which the host holds its output enable low.

A single strobe yields at most 128 delivered words. After that the sequencer parks until the next strobe. While the array reports that it is programming or erasing, the data output carries a status word and ready stays low. The burst is abandoned and only a new strobe, taken while the array is idle, restarts it.

The controller has five states. IDLE is entered from reset. LATENCY counts the wait states. STREAM delivers words. HALT is entered after the 128-word cap. STATUS is the busy override.

The transitions are as follows:
- strobe-to-LATENCY, taken when the wait count is non-zero.
- strobe-to-STREAM, taken when the wait count is zero.
- LATENCY-to-STREAM, on the last wait cycle.
- STREAM-to-HALT, on the 128th delivery.
- any-to-STATUS, whenever busy is sampled high.

A strobe from HALT or STATUS leaves by the strobe transitions.

Top module: `burst_wrap_seq`

## Requirements
- R1: After reset, `ready` is 0 and `mem_addr` is 0, and both stay that way until a strobe is taken.
- R2: A clock edge with `adv_n` low and `array_busy` low captures `start_addr`, `wrap_mode` and `wait_cfg`. The first word delivered after it is at `start_addr`.
- R3: Each delivery increments only the low in-group bits of `mem_addr`, wrapping from the group top to the group base. The number of low bits depends on the mode: 3 for `wrap_mode`=00 (8 words), 4 for 01 (16 words), and 5 for 10 or 11 (32 words). Bits 5 and above never change during a burst.
- R4: With a captured wait count N, `ready` is low for exactly N cycles after the strobe edge. It is high in the cycle that follows, provided `oe_n` is low. N=0 gives data in the first cycle.
- R5: Once the first word is delivered, every following cycle with `oe_n` low delivers the next word with no inserted wait.
- R6: A cycle with `oe_n` high in STREAM has `ready` low, keeps `mem_addr` unchanged and does not count toward the cap.
- R7: After 128 deliveries from one strobe, `ready` stays low and `mem_addr` holds until the next strobe.
- R8: While `array_busy` is high, `data_out` equals `status_word` and `ready` is low. An edge that samples busy high moves the block to STATUS with the address frozen. It stays there, with `ready` low, after busy falls and until a strobe is taken.
- R9: A strobe taken in any state restarts the burst from the new start address with a fresh wait count.
- R10: A strobe whose edge also samples `array_busy` high is not taken. The block goes to STATUS and delivers nothing after busy falls.
- R11: While `array_busy` is low, `data_out` equals `array_data`.
- R12: Changing `wrap_mode` or `wait_cfg` after the strobe edge has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_n | input | 1 | Active-low address strobe |
| start_addr | input | ADDR_W | Burst start word address |
| wrap_mode | input | 2 | Group size: 00=8, 01=16, 10/11=32 words |
| wait_cfg | input | WAIT_W | Initial wait-state count |
| oe_n | input | 1 | Active-low host output enable |
| array_busy | input | 1 | Array is programming or erasing |
| array_data | input | DATA_W | Word read from the array |
| status_word | input | DATA_W | Status word shown while busy |
| mem_addr | output | ADDR_W | Word address to the array |
| data_out | output | DATA_W | Word returned to the host |
| ready | output | 1 | A valid word is on `data_out` this cycle |

## Verification
Two functions can fall in the same cycle: the address strobe and the busy override. The bench provokes this by raising `adv_n` low and `array_busy` high before one and the same clock edge. It then drops busy and watches `ready` for longer than any wait count could last, expecting no delivery. A second collision puts a busy pulse into a running stream. The bench then checks that the status word replaces array data at once and that the address stays frozen until a clean strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATENCY,
        ST_STREAM,
        ST_HALT,
        ST_STATUS
    } seq_state_e;

    typedef enum logic [1:0] {
        WRAP8   = 2'b00,
        WRAP16  = 2'b01,
        WRAP32  = 2'b10,
        WRAP32X = 2'b11
    } wrap_mode_e;

    // width of the in-group field for the narrowest group
    localparam int BASE_GROUP_BITS = 3;
    // number of distinct group sizes
    localparam int GROUP_VARIANTS  = 3;

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        mode_in,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    wrap_mode_e        mode_q;
    logic [ADDR_W-1:0] cand [GROUP_VARIANTS];

    // one wrapped-increment candidate per group size
    genvar g;
    generate
        for (g = 0; g < GROUP_VARIANTS; g++) begin : g_wrap
            localparam int GB = BASE_GROUP_BITS + g;
            logic [GB-1:0] low_inc;
            assign low_inc = addr_q[GB-1:0] + 1'b1;
            assign cand[g] = {addr_q[ADDR_W-1:GB], low_inc};
        end
    endgenerate

    always_comb begin
        case (mode_q)
            WRAP8:   addr_next = cand[0];
            WRAP16:  addr_next = cand[1];
            default: addr_next = cand[2];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= WRAP8;
        end else if (load) begin
            addr_q <= start_addr;
            mode_q <= wrap_mode_e'(mode_in);
        end else if (step) begin
            addr_q <= addr_next;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/burst_lat_cnt.sv
module burst_lat_cnt #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [WAIT_W-1:0] wait_in,
    output logic              lat_last
);

    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= wait_in;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign lat_last = (cnt_q == ONE);

endmodule

// File: rtl/burst_word_cnt.sv
module burst_word_cnt #(
    parameter int MAX_WORDS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    localparam int               CNT_W = $clog2(MAX_WORDS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(MAX_WORDS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == LAST);

endmodule

// File: rtl/burst_wrap_seq.sv
module burst_wrap_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int WAIT_W    = 4,
    parameter int DATA_W    = 16,
    parameter int MAX_WORDS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        wrap_mode,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              oe_n,
    input  logic              array_busy,
    input  logic [DATA_W-1:0] array_data,
    input  logic [DATA_W-1:0] status_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] data_out,
    output logic              ready
);

    seq_state_e state_q, state_d;

    logic take_strobe;
    logic deliver;
    logic advance;
    logic lat_tick;
    logic lat_last;
    logic word_last;

    // a strobe is only taken while the array is idle
    assign take_strobe = !adv_n && !array_busy;
    assign deliver     = (state_q == ST_STREAM) && !oe_n && !array_busy;
    assign advance     = deliver && adv_n;
    assign lat_tick    = (state_q == ST_LATENCY) && adv_n && !array_busy;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_strobe),
        .step       (advance),
        .start_addr (start_addr),
        .mode_in    (wrap_mode),
        .addr       (mem_addr)
    );

    burst_lat_cnt #(.WAIT_W(WAIT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_strobe),
        .tick     (lat_tick),
        .wait_in  (wait_cfg),
        .lat_last (lat_last)
    );

    burst_word_cnt #(.MAX_WORDS(MAX_WORDS)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take_strobe),
        .inc     (advance),
        .at_last (word_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (array_busy) begin
            state_d = ST_STATUS;
        end else if (!adv_n) begin
            state_d = (wait_cfg == '0) ? ST_STREAM : ST_LATENCY;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_LATENCY: if (lat_last) state_d = ST_STREAM;
                ST_STREAM:  if (deliver && word_last) state_d = ST_HALT;
                ST_HALT:    state_d = ST_HALT;
                ST_STATUS:  state_d = ST_STATUS;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        ready    = deliver;
        data_out = array_busy ? status_word : array_data;
    end

endmodule

// File: rtl/burst_wrap_seq_chk.sv
module burst_wrap_seq_chk #(
    parameter int ADDR_W    = 21,
    parameter int WAIT_W    = 4,
    parameter int MAX_WORDS = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_n,
    input logic [WAIT_W-1:0] wait_cfg,
    input logic              oe_n,
    input logic              array_busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ready
);

    localparam int              CW  = $clog2(MAX_WORDS) + 1;
    localparam logic [CW-1:0]   CAP = CW'(MAX_WORDS);

    logic [CW-1:0] seen_q;

    // deliveries since the last strobe, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (!adv_n) begin
            seen_q <= '0;
        end else if (ready && seen_q != CAP) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && adv_n) |=> (mem_addr[ADDR_W-1:5] == $past(mem_addr[ADDR_W-1:5])));

    assert_first_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_n && !array_busy && wait_cfg != '0) |=> !ready);

    assert_oe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && adv_n && !array_busy) |=> $stable(mem_addr));

    assert_burst_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == CAP) |-> !ready);

    assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        array_busy |-> !ready);

    assert_busy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        array_busy |=> !ready);

endmodule

bind burst_wrap_seq burst_wrap_seq_chk #(
    .ADDR_W    (ADDR_W),
    .WAIT_W    (WAIT_W),
    .MAX_WORDS (MAX_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_n      (adv_n),
    .wait_cfg   (wait_cfg),
    .oe_n       (oe_n),
    .array_busy (array_busy),
    .mem_addr   (mem_addr),
    .ready      (ready)
);

// File: tb/tb_burst_wrap_seq.sv
module tb_burst_wrap_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 21;
    localparam int WAIT_W     = 4;
    localparam int DATA_W     = 16;
    localparam int MAX_WORDS  = 128;
    localparam logic [DATA_W-1:0] STATUS = 16'h0080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              adv_n = 1'b1;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [1:0]        wrap_mode = 2'b00;
    logic [WAIT_W-1:0] wait_cfg = '0;
    logic              oe_n = 1'b0;
    logic              array_busy = 1'b0;
    logic [DATA_W-1:0] array_data;
    logic [DATA_W-1:0] status_word = STATUS;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] data_out;
    logic              ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // the array model: data is a fixed function of the address
    assign array_data = mem_addr[DATA_W-1:0] ^ 16'hA5A5;

    burst_wrap_seq #(
        .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .start_addr(start_addr),
        .wrap_mode(wrap_mode), .wait_cfg(wait_cfg), .oe_n(oe_n),
        .array_busy(array_busy), .array_data(array_data),
        .status_word(status_word), .mem_addr(mem_addr),
        .data_out(data_out), .ready(ready)
    );

    function automatic logic [ADDR_W-1:0] ref_next(logic [ADDR_W-1:0] a, logic [1:0] m);
        int gb;
        logic [ADDR_W-1:0] msk;
        gb  = (m == 2'b00) ? 3 : (m == 2'b01) ? 4 : 5;
        msk = (ADDR_W'(1) << gb) - ADDR_W'(1);
        return (a & ~msk) | ((a + ADDR_W'(1)) & msk);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // strobe, then scramble the config inputs (R12)
    task automatic strobe(input logic [ADDR_W-1:0] a, input logic [1:0] m, input logic [WAIT_W-1:0] w);
        @(negedge clk);
        adv_n = 1'b0; start_addr = a; wrap_mode = m; wait_cfg = w;
        @(negedge clk);
        adv_n = 1'b1; start_addr = ~a; wrap_mode = ~m; wait_cfg = ~w;
        #1;
    endtask

    task automatic expect_latency(input int n);
        for (int i = 0; i < n; i++) begin
            chk(ready == 1'b0, "R4 latency ready", 32'(ready), 0);
            step();
        end
    endtask

    task automatic expect_words(input logic [ADDR_W-1:0] a0, input logic [1:0] m, input int n);
        logic [ADDR_W-1:0] a;
        a = a0;
        for (int i = 0; i < n; i++) begin
            chk(ready == 1'b1, (i == 0) ? "R4 first ready" : "R5 stream ready", 32'(ready), 1);
            chk(mem_addr == a, (i == 0) ? "R2 start addr" : "R3 wrap addr", 32'(mem_addr), 32'(a));
            chk(data_out == (a[DATA_W-1:0] ^ 16'hA5A5), "R11 data path", 32'(data_out),
                32'(a[DATA_W-1:0] ^ 16'hA5A5));
            a = ref_next(a, m);
            step();
        end
    endtask

    task automatic t_reset();
        chk(ready == 1'b0, "R1 reset ready", 32'(ready), 0);
        chk(mem_addr == '0, "R1 reset addr", 32'(mem_addr), 0);
        step(); step();
        chk(ready == 1'b0, "R1 idle ready", 32'(ready), 0);
    endtask

    task automatic t_example();
        strobe(21'h39, 2'b00, 4'd2);
        expect_latency(2);
        expect_words(21'h39, 2'b00, 9);
        chk(mem_addr == 21'h3A, "R3 second pass", 32'(mem_addr), 32'h3A);
    endtask

    task automatic t_full_burst(input logic [1:0] m, input logic [WAIT_W-1:0] w);
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] held;
        a = ADDR_W'($urandom);
        strobe(a, m, w);
        expect_latency(int'(w));
        expect_words(a, m, MAX_WORDS);
        held = mem_addr;
        for (int i = 0; i < 4; i++) begin
            chk(ready == 1'b0, "R7 halt ready", 32'(ready), 0);
            chk(mem_addr == held, "R7 halt addr", 32'(mem_addr), 32'(held));
            step();
        end
    endtask

    task automatic t_pause();
        logic [ADDR_W-1:0] a;
        a = 21'h1ABCD;
        strobe(a, 2'b01, 4'd1);
        expect_latency(1);
        expect_words(a, 2'b01, 5);
        oe_n = 1'b1; #1;
        for (int i = 0; i < 3; i++) begin
            chk(ready == 1'b0, "R6 oe high ready", 32'(ready), 0);
            chk(mem_addr == 21'h1ABC2, "R6 oe high addr", 32'(mem_addr), 32'h1ABC2);
            step();
        end
        oe_n = 1'b0; #1;
        expect_words(21'h1ABC2, 2'b01, 5);
    endtask

    task automatic t_abort();
        strobe(21'h00F3, 2'b10, 4'd3);
        expect_latency(3);
        expect_words(21'h00F3, 2'b10, 10);
        strobe(21'h12345, 2'b00, 4'd4);
        expect_latency(4);
        expect_words(21'h12345, 2'b00, 10);
        chk(1'b1, "R9 abort", 0, 0);
    endtask

    task automatic t_busy();
        logic [ADDR_W-1:0] frozen;
        strobe(21'h0450, 2'b01, 4'd0);
        expect_words(21'h0450, 2'b01, 6);
        frozen = mem_addr;
        array_busy = 1'b1; #1;
        chk(ready == 1'b0, "R8 busy ready", 32'(ready), 0);
        chk(data_out == STATUS, "R8 status word", 32'(data_out), 32'(STATUS));
        step(); step();
        chk(data_out == STATUS, "R8 status hold", 32'(data_out), 32'(STATUS));
        array_busy = 1'b0; #1;
        for (int i = 0; i < 4; i++) begin
            chk(ready == 1'b0, "R8 status sticky", 32'(ready), 0);
            chk(mem_addr == frozen, "R8 addr frozen", 32'(mem_addr), 32'(frozen));
            step();
        end
        strobe(21'h0777, 2'b00, 4'd0);
        expect_words(21'h0777, 2'b00, 3);
    endtask

    task automatic t_collide();
        @(negedge clk);
        adv_n = 1'b0; array_busy = 1'b1;
        start_addr = 21'h0BEEF; wrap_mode = 2'b00; wait_cfg = 4'd1;
        @(negedge clk);
        adv_n = 1'b1; array_busy = 1'b0;
        #1;
        for (int i = 0; i < 20; i++) begin
            chk(ready == 1'b0, "R10 collide no data", 32'(ready), 0);
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_example();
        t_full_burst(2'b00, 4'd0);
        t_full_burst(2'b01, 4'd5);
        t_full_burst(2'b10, 4'd15);
        t_full_burst(2'b11, 4'd2);
        for (int k = 0; k < 6; k++) begin
            t_full_burst(2'($urandom % 3), WAIT_W'($urandom % 8));
        end
        t_pause();
        t_abort();
        t_busy();
        t_collide();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule